// File: doc/BRIEF.md
# Cacheline-to-Flit Packetizer

The block turns one 64-byte cacheline write into a fixed packet of nine 80-bit flits for a link transmitter. An upstream agent offers a header word together with the 512-bit line on a valid/ready input. The block captures both in a single transfer, then drives the packet on a valid/ready flit output. The header word goes out first, unchanged. Eight data flits follow it.

Each data flit holds one 64-bit chunk of the line in its low bits. Above the chunk sits a 16-bit side field. That field carries the chunk index and a flag that marks the final chunk. The upper side bits are zero. A separate last output marks the ninth flit.

Back-pressure rules: input and output both follow the usual handshake rule, where a transfer happens on a clock edge at which valid and ready are both high. The input is ready only while no packet is in flight, so one line is held at a time. While the output is valid and ready is low, the flit and the last output hold steady until the flit is taken. The sender's valid must not depend on ready. Out of reset the block is idle and ready.

Top module: `flit_packetizer`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and out_last is 0.
- R2: in_ready is 1 only when no packet is in flight. While out_valid is 1, in_ready is 0, and the values on in_hdr, in_line and in_valid have no effect on the packet being sent.
- R3: The first flit of each packet, numbered flit 0, equals the captured in_hdr word bit for bit. It appears on the cycle after the input transfer.
- R4: Flit k, for k = 1 to 8, carries line bits [64(k-1)+63 : 64(k-1)] in out_flit[63:0]. Chunks therefore go out in ascending address order, starting with bytes 0 to 7.
- R5: In data flit k, out_flit[66:64] equals k-1, out_flit[67] is 1 only for k = 8, and out_flit[79:68] is zero.
- R6: Every packet is exactly nine flits long. out_last is 1 with the ninth flit and 0 with every other flit.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_flit and out_last stay unchanged on the next cycle. No flit is dropped or repeated.
- R8: On the cycle after the ninth flit is taken, the block is idle again: in_ready is 1 and out_valid is 0. A new line can be accepted on that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Line request offered |
| in_ready | output | 1 | Block is idle and can take a line |
| in_hdr | input | 80 | Header word, sent as flit 0 |
| in_line | input | 512 | Cacheline data, byte 0 in bits [7:0] |
| out_valid | output | 1 | Flit on out_flit is valid |
| out_ready | input | 1 | Downstream takes the flit |
| out_flit | output | 80 | Current flit |
| out_last | output | 1 | Current flit is the ninth of its packet |

## Verification
The bench sends lines with a distinct value in every byte. Any swap of chunk order or misplaced bit range then shows up in a single packet. It also uses all-ones and all-zeros lines, which show whether the side field and its zero bits stay intact when the data is saturated. Each pattern runs with an output that is always ready, with a pseudo-random ready and with a sparse periodic ready, which exposes lost, repeated or shifted flits under stalls. Some runs keep the input valid with changed data during a packet, and one runs two packets back to back, to show that a line in flight cannot be overwritten and that the return to idle takes exactly one cycle.

// File: rtl/pkt_pkg.sv
package pkt_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } pkt_state_t;

  localparam int DEF_CHUNK_W  = 64;
  localparam int DEF_N_CHUNKS = 8;
  localparam int DEF_SIDE_W   = 16;
endpackage

// File: rtl/pkt_store.sv
module pkt_store #(
  parameter int HDR_W  = 80,
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              load,
  input  logic [HDR_W-1:0]  hdr_in,
  input  logic [LINE_W-1:0] line_in,
  output logic [HDR_W-1:0]  hdr_q,
  output logic [LINE_W-1:0] line_q
);
  // Data-path registers: they need no reset, since valid is tracked elsewhere
  always_ff @(posedge clk) begin
    if (load) begin
      hdr_q  <= hdr_in;
      line_q <= line_in;
    end
  end
endmodule

// File: rtl/pkt_seq.sv
module pkt_seq
  import pkt_pkg::*;
#(
  parameter int N_CHUNKS = 8,
  parameter int BEAT_W   = $clog2(N_CHUNKS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              load,
  output logic              last,
  output logic [BEAT_W-1:0] beat
);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(N_CHUNKS);

  pkt_state_t state;
  logic       fire;

  assign in_ready  = (state == ST_IDLE);
  assign out_valid = (state == ST_SEND);
  assign load      = in_valid && in_ready;
  assign fire      = out_valid && out_ready;
  assign last      = out_valid && (beat == LAST_BEAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      beat  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load) begin
            state <= ST_SEND;
            beat  <= '0;
          end
        end
        ST_SEND: begin
          if (fire) begin
            if (beat == LAST_BEAT) begin
              state <= ST_IDLE;
              beat  <= '0;
            end else begin
              beat <= beat + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_fmt.sv
module pkt_fmt #(
  parameter int CHUNK_W  = 64,
  parameter int N_CHUNKS = 8,
  parameter int SIDE_W   = 16,
  parameter int FLIT_W   = CHUNK_W + SIDE_W,
  parameter int LINE_W   = CHUNK_W * N_CHUNKS,
  parameter int BEAT_W   = $clog2(N_CHUNKS + 1)
) (
  input  logic [FLIT_W-1:0] hdr_q,
  input  logic [LINE_W-1:0] line_q,
  input  logic [BEAT_W-1:0] beat,
  output logic [FLIT_W-1:0] flit
);
  localparam int IDX_W = (N_CHUNKS > 1) ? $clog2(N_CHUNKS) : 1;
  localparam int PAD_W = SIDE_W - IDX_W - 1;

  logic [FLIT_W-1:0] data_flit [N_CHUNKS];
  logic [IDX_W-1:0]  sel;

  for (genvar k = 0; k < N_CHUNKS; k++) begin : g_chunk
    localparam logic [IDX_W-1:0] KI     = IDX_W'(k);
    localparam logic             IS_END = (k == N_CHUNKS - 1);
    assign data_flit[k] = {{PAD_W{1'b0}}, IS_END, KI,
                           line_q[k*CHUNK_W +: CHUNK_W]};
  end

  assign sel = IDX_W'(beat - 1'b1);

  always_comb begin
    if (beat == '0) flit = hdr_q;
    else            flit = data_flit[sel];
  end
endmodule

// File: rtl/flit_packetizer.sv
module flit_packetizer
  import pkt_pkg::*;
#(
  parameter int CHUNK_W  = DEF_CHUNK_W,
  parameter int N_CHUNKS = DEF_N_CHUNKS,
  parameter int SIDE_W   = DEF_SIDE_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [CHUNK_W+SIDE_W-1:0]     in_hdr,
  input  logic [CHUNK_W*N_CHUNKS-1:0]   in_line,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [CHUNK_W+SIDE_W-1:0]     out_flit,
  output logic                          out_last
);
  localparam int FLIT_W = CHUNK_W + SIDE_W;
  localparam int LINE_W = CHUNK_W * N_CHUNKS;
  localparam int BEAT_W = $clog2(N_CHUNKS + 1);

  logic              load;
  logic [BEAT_W-1:0] beat;
  logic [FLIT_W-1:0] hdr_q;
  logic [LINE_W-1:0] line_q;

  pkt_seq #(.N_CHUNKS(N_CHUNKS), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_ready(out_ready),
    .in_ready(in_ready), .out_valid(out_valid), .load(load),
    .last(out_last), .beat(beat)
  );

  pkt_store #(.HDR_W(FLIT_W), .LINE_W(LINE_W)) u_store (
    .clk(clk), .load(load), .hdr_in(in_hdr), .line_in(in_line),
    .hdr_q(hdr_q), .line_q(line_q)
  );

  pkt_fmt #(.CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS), .SIDE_W(SIDE_W),
            .FLIT_W(FLIT_W), .LINE_W(LINE_W), .BEAT_W(BEAT_W)) u_fmt (
    .hdr_q(hdr_q), .line_q(line_q), .beat(beat), .flit(out_flit)
  );
endmodule

// File: rtl/pkt_checker.sv
module pkt_checker #(
  parameter int CHUNK_W  = 64,
  parameter int N_CHUNKS = 8,
  parameter int SIDE_W   = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      in_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic [CHUNK_W+SIDE_W-1:0] out_flit,
  input logic                      out_last
);
  localparam int IDX_W = (N_CHUNKS > 1) ? $clog2(N_CHUNKS) : 1;
  localparam int CNT_W = $clog2(N_CHUNKS + 1);
  localparam int PAD_W = SIDE_W - IDX_W - 1;

  logic [CNT_W-1:0] cnt;

  // Independent count of flits taken within the current packet
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (out_valid && out_ready) cnt <= out_last ? '0 : cnt + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (in_ready && !out_valid && !out_last));

  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_side_index_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && cnt != '0) |->
      (out_flit[CHUNK_W +: IDX_W] == IDX_W'(cnt - 1'b1)) &&
      (out_flit[CHUNK_W+IDX_W+1 +: PAD_W] == '0));

  p_last_ninth_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_last == (cnt == CNT_W'(N_CHUNKS))));

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_flit) && $stable(out_last)));

  p_idle_after_last_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

  logic unused_in_valid;
  assign unused_in_valid = in_valid;
endmodule

bind flit_packetizer pkt_checker #(
  .CHUNK_W(CHUNK_W), .N_CHUNKS(N_CHUNKS), .SIDE_W(SIDE_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
  .out_last(out_last)
);

// File: tb/tb_flit_packetizer.sv
`timescale 1ns/1ps
module tb_flit_packetizer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [79:0]  in_hdr = '0;
  logic [511:0] in_line = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [79:0]  out_flit;
  logic         out_last;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  flit_packetizer dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_hdr(in_hdr), .in_line(in_line), .out_valid(out_valid),
    .out_ready(out_ready), .out_flit(out_flit), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] exp_flit(input logic [79:0] hdr,
                                           input logic [511:0] line,
                                           input int k);
    logic [2:0] ki;
    if (k == 0) return hdr;
    ki = 3'(k - 1);
    return {12'h000, (k == 8), ki, line[64*(k-1) +: 64]};
  endfunction

  function automatic bit pick_ready(input int mode, input int cyc);
    if (mode == 0) return 1'b1;
    if (mode == 1) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      return lfsr[0];
    end
    return (cyc % 3) == 0;
  endfunction

  // Offer one line, then drain its nine flits under the chosen ready pattern
  task automatic run_packet(input logic [79:0] hdr, input logic [511:0] line,
                            input int mode, input bit poke, input string tag);
    int idx = 0;
    int cyc = 0;
    bit held = 0;
    logic [79:0] hflit = '0;
    logic [79:0] e;
    @(negedge clk);
    chk(in_ready && !out_valid, {"R2 idle before ", tag}, 80'(in_ready), 80'd1);
    in_valid = 1'b1;
    in_hdr   = hdr;
    in_line  = line;
    while (idx < 9 && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (held)
        chk(out_valid && out_flit == hflit, {"R7 stall hold ", tag}, out_flit, hflit);
      held = 0;
      if (!poke) in_valid = 1'b0;
      chk(out_valid && !in_ready, {"R2 busy ", tag}, 80'(in_ready), 80'd0);
      out_ready = pick_ready(mode, cyc);
      if (out_valid && out_ready) begin
        e = exp_flit(hdr, line, idx);
        if (idx == 0) chk(out_flit == e, {"R3 header ", tag}, out_flit, e);
        else begin
          chk(out_flit[63:0] == e[63:0], {"R4 data ", tag}, out_flit, e);
          chk(out_flit[79:64] == e[79:64], {"R5 side ", tag}, out_flit, e);
        end
        chk(out_last == (idx == 8), {"R6 last ", tag}, 80'(out_last), 80'(idx == 8));
        idx++;
      end else if (out_valid) begin
        held  = 1;
        hflit = out_flit;
      end
      if (poke) begin
        in_hdr   = ~hdr;
        in_line  = {line[255:0], ~line[511:256]};
        in_valid = (idx < 9);
      end
    end
    chk(idx == 9, {"R6 count ", tag}, 80'(idx), 80'd9);
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready && !out_valid, {"R8 idle after ", tag}, 80'(in_ready), 80'd1);
  endtask

  function automatic logic [511:0] byte_ramp(input logic [7:0] seed);
    logic [511:0] v;
    for (int b = 0; b < 64; b++) v[8*b +: 8] = 8'(seed + 8'(b));
    return v;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(in_ready, "R1 in_ready", 80'(in_ready), 80'd1);
    chk(!out_valid, "R1 out_valid", 80'(out_valid), 80'd0);
    chk(!out_last, "R1 out_last", 80'(out_last), 80'd0);
  endtask

  task automatic t_basic();
    run_packet(80'h1234_5678_9ABC_DEF0_1357, byte_ramp(8'h00), 0, 0, "ramp");
  endtask

  task automatic t_stall_random();
    run_packet(80'hFEDC_BA98_7654_3210_ABCD, byte_ramp(8'h40), 1, 0, "random ready");
  endtask

  task automatic t_stall_sparse();
    run_packet(80'h0F0F_F0F0_0F0F_F0F0_5A5A, byte_ramp(8'h81), 2, 0, "sparse ready");
  endtask

  task automatic t_ignore_input();
    run_packet(80'hAAAA_5555_AAAA_5555_AAAA, byte_ramp(8'hC3), 1, 1, "poke busy");
  endtask

  task automatic t_extremes();
    run_packet({80{1'b1}}, {512{1'b1}}, 0, 0, "all ones");
    run_packet('0, '0, 2, 1, "all zeros");
  endtask

  task automatic t_back_to_back();
    run_packet(80'h1111_2222_3333_4444_5555, byte_ramp(8'h10), 0, 0, "b2b first");
    run_packet(80'h6666_7777_8888_9999_AAAA, byte_ramp(8'h90), 0, 0, "b2b second");
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_stall_random();
    t_stall_sparse();
    t_ignore_input();
    t_extremes();
    t_back_to_back();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule